// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block collects every interrupt condition of a single UART channel and reports the one with the highest priority as a 3-bit identification code. It also drives an interrupt request line. The receive FIFO, the serial engines, the modem-signal logic and the flow-control detectors all live outside the block. They supply condition flags, and software register reads supply clear strobes. The block holds event-type conditions in latches and samples level-type conditions directly. It then masks them with per-source enables and encodes the result into a registered code.

Each source has its own clearing rule:
- The receive-level source follows the FIFO trigger comparison.
- Line errors clear on a line-status read.
- The receive time-out clears when receive data is read.
- Transmit-ready clears on an identification-register read while code 3 is shown.
- Modem deltas clear on a modem-status read.
- Flow-control and special-character events clear on an identification-register read while code 4 is shown.
- The timer clears on a timer-control read.

A parameter chooses whether the instance carries the timer source, which is wanted for channel 0 only.

Top module: `uart_int_id`

## Requirements
- R1: After synchronous reset, `isr_code` is 000 and `irq` is 0.
- R2: Code 001 is reported when `rx_at_trig` is high, or when a pulse on any bit of `line_err[3:0]` has been latched. The line-error latch clears on `line_rd`, and the level part drops once `rx_at_trig` falls. A condition present in cycle n is reflected in `isr_code` after the second following rising edge.
- R3: A pulse on `rx_tmo` gives code 010, which stays until a receive data read (`rx_rd`) clears it.
- R4: A rising edge of the selected empty flag gives code 011. The selected flag is `thr_empty` when `auto485` is 0 and `tsr_empty` when it is 1, and the unselected flag has no effect. A steady high flag gives no new event. The source clears on `isr_rd` while the code is 011.
- R5: Code 100 is reported for a `modem_delta` pulse, which clears only on `modem_rd`, and for a `flow_evt` pulse, which clears on `isr_rd` while the code is 100.
- R6: Priority is fixed with 001 highest, then 010, 011, 100, and 111 lowest. A lower source becomes visible once the higher ones clear.
- R7: Codes 101 and 110 are never produced.
- R8: With `HAS_TIMER`=1, a `tmr_to` pulse gives code 111, which clears on `tmr_rd`. With `HAS_TIMER`=0, `tmr_to` never affects the code.
- R9: `ien` bits map to sources as follows: 0 receive level, 1 line error, 2 time-out, 3 transmit, 4 modem, 5 flow, 6 timer. A source whose bit is 0 never drives the code. Its latch still records events, so setting the bit later reveals them after one rising edge.
- R10: In the cycle in which `isr_rd` clears a source, `isr_code` still shows the pre-clear code. The next pending code follows one cycle later.
- R11: `irq` is 1 exactly when `isr_code` is non-zero.
- R12: When a source's set event and its clear strobe fall in the same cycle, the set wins and the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ien | input | 7 | Per-source enables (see R9) |
| rx_at_trig | input | 1 | RX FIFO level at or above its trigger |
| rx_rd | input | 1 | Receive data read strobe |
| line_err | input | 4 | Line error event pulses |
| line_rd | input | 1 | Line-status register read strobe |
| rx_tmo | input | 1 | Receive time-out event pulse |
| thr_empty | input | 1 | Transmit holding register empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| auto485 | input | 1 | Selects shift-register empty as transmit-ready |
| modem_delta | input | 1 | Modem or handshake line change pulse |
| modem_rd | input | 1 | Modem-status register read strobe |
| flow_evt | input | 1 | Xon/Xoff or special-character detect pulse |
| isr_rd | input | 1 | Identification register read strobe |
| tmr_to | input | 1 | Timer time-out pulse |
| tmr_rd | input | 1 | Timer control register read strobe |
| isr_code | output | 3 | Registered identification code |
| irq | output | 1 | Interrupt request |

## Verification
A source's new event and the read that clears it can land in the same cycle. The bench provokes this twice: a fresh flow-control pulse together with an identification read while code 100 is shown, and a modem delta together with a modem-status read. The expected result is that the code stays at 100 two edges later. A further plain read then brings the code to 000, which shows that the latch truly survived rather than being re-set by chance.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;
  localparam int NSRC    = 7;
  localparam int SRC_RXL = 0;
  localparam int SRC_LSR = 1;
  localparam int SRC_TMO = 2;
  localparam int SRC_TX  = 3;
  localparam int SRC_MSR = 4;
  localparam int SRC_FLW = 5;
  localparam int SRC_TMR = 6;

  typedef enum logic [2:0] {
    INT_NONE   = 3'd0,
    INT_RXLINE = 3'd1,
    INT_RXTMO  = 3'd2,
    INT_TXRDY  = 3'd3,
    INT_FLOW   = 3'd4,
    INT_TMR    = 3'd7
  } int_code_t;
endpackage

// File: rtl/uart_int_latch.sv
module uart_int_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  // set beats a simultaneous clear
  assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q);
  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q);
endmodule

// File: rtl/uart_int_enc.sv
module uart_int_enc
  import uart_int_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  output int_code_t       code
);
  always_comb begin
    if (pend[SRC_RXL] || pend[SRC_LSR])      code = INT_RXLINE;
    else if (pend[SRC_TMO])                  code = INT_RXTMO;
    else if (pend[SRC_TX])                   code = INT_TXRDY;
    else if (pend[SRC_MSR] || pend[SRC_FLW]) code = INT_FLOW;
    else if (pend[SRC_TMR])                  code = INT_TMR;
    else                                     code = INT_NONE;
  end

  always_comb begin
    assert_enc_order_R6: assert ((pend == '0) == (code == INT_NONE));
  end
endmodule

// File: rtl/uart_int_id.sv
module uart_int_id
  import uart_int_pkg::*;
#(
  parameter bit HAS_TIMER = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ien,
  input  logic            rx_at_trig,
  input  logic            rx_rd,
  input  logic [3:0]      line_err,
  input  logic            line_rd,
  input  logic            rx_tmo,
  input  logic            thr_empty,
  input  logic            tsr_empty,
  input  logic            auto485,
  input  logic            modem_delta,
  input  logic            modem_rd,
  input  logic            flow_evt,
  input  logic            isr_rd,
  input  logic            tmr_to,
  input  logic            tmr_rd,
  output logic [2:0]      isr_code,
  output logic            irq
);
  logic [NSRC-1:0] held, set_v, clr_v;
  logic            tx_sel, tx_prev;
  int_code_t       code_d, code_q;

  // transmit-ready: rising edge of the selected empty flag
  assign tx_sel = auto485 ? tsr_empty : thr_empty;
  always_ff @(posedge clk) begin
    if (rst) tx_prev <= 1'b1;
    else     tx_prev <= tx_sel;
  end

  always_comb begin
    set_v          = '0;
    clr_v          = '0;
    set_v[SRC_LSR] = |line_err;
    clr_v[SRC_LSR] = line_rd;
    set_v[SRC_TMO] = rx_tmo;
    clr_v[SRC_TMO] = rx_rd;
    set_v[SRC_TX]  = tx_sel && !tx_prev;
    clr_v[SRC_TX]  = isr_rd && (code_q == INT_TXRDY);
    set_v[SRC_MSR] = modem_delta;
    clr_v[SRC_MSR] = modem_rd;
    set_v[SRC_FLW] = flow_evt;
    clr_v[SRC_FLW] = isr_rd && (code_q == INT_FLOW);
    set_v[SRC_TMR] = tmr_to;
    clr_v[SRC_TMR] = tmr_rd;
  end

  // level source: sampled, not latched
  always_ff @(posedge clk) begin
    if (rst) held[SRC_RXL] <= 1'b0;
    else     held[SRC_RXL] <= rx_at_trig;
  end

  for (genvar i = 1; i < NSRC; i++) begin : g_src
    if (i == SRC_TMR && !HAS_TIMER) begin : g_absent
      assign held[i] = 1'b0;
    end else begin : g_present
      uart_int_latch u_lat (
        .clk  (clk),
        .rst  (rst),
        .set_i(set_v[i]),
        .clr_i(clr_v[i]),
        .q    (held[i])
      );
    end
  end

  uart_int_enc u_enc (
    .pend(held & ien),
    .code(code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= INT_NONE;
      irq    <= 1'b0;
    end else begin
      code_q <= code_d;
      irq    <= (code_d != INT_NONE);
    end
  end

  assign isr_code = code_q;

  assert_no_reserved_R7: assert property (@(posedge clk) disable iff (rst)
    (isr_code != 3'd5) && (isr_code != 3'd6));
  assert_irq_match_R11: assert property (@(posedge clk) disable iff (rst)
    irq == (isr_code != 3'd0));
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> (isr_code == 3'd0));
  assert_modem_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (held[SRC_MSR] && !modem_rd) |=> held[SRC_MSR]);
  if (!HAS_TIMER) begin : g_chk_tmr
    assert_no_timer_R8: assert property (@(posedge clk) disable iff (rst)
      isr_code != 3'd7);
  end
endmodule

// File: tb/sim_uart_int_id.sv
module sim_uart_int_id;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [6:0] ien = 7'h7F;
  logic rx_at_trig = 0, rx_rd = 0, line_rd = 0, rx_tmo = 0;
  logic [3:0] line_err = 4'h0;
  logic thr_empty = 0, tsr_empty = 0, auto485 = 0;
  logic modem_delta = 0, modem_rd = 0, flow_evt = 0, isr_rd = 0;
  logic tmr_to = 0, tmr_rd = 0;
  logic [2:0] code0, code1;
  logic irq0, irq1;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_int_id #(.HAS_TIMER(1'b1)) u0 (
    .clk, .rst, .ien, .rx_at_trig, .rx_rd, .line_err, .line_rd, .rx_tmo,
    .thr_empty, .tsr_empty, .auto485, .modem_delta, .modem_rd, .flow_evt,
    .isr_rd, .tmr_to, .tmr_rd, .isr_code(code0), .irq(irq0));

  uart_int_id #(.HAS_TIMER(1'b0)) u1 (
    .clk, .rst, .ien, .rx_at_trig, .rx_rd, .line_err, .line_rd, .rx_tmo,
    .thr_empty, .tsr_empty, .auto485, .modem_delta, .modem_rd, .flow_evt,
    .isr_rd, .tmr_to, .tmr_rd, .isr_code(code1), .irq(irq1));

  task automatic check(input logic [2:0] got, input logic [2:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one negedge later, drop every pulse input
  task automatic step();
    tick(1);
    rx_rd = 0; line_rd = 0; rx_tmo = 0; line_err = 4'h0;
    modem_delta = 0; modem_rd = 0; flow_evt = 0; isr_rd = 0;
    tmr_to = 0; tmr_rd = 0;
  endtask

  // stimulus already applied: let two edges pass, then queue expectation
  task automatic expect_code(input logic [2:0] c, input string tag);
    step();
    tick(1);
    exp_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  // monitor: compares code and irq against the queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(code0, e, t);
        check({2'b00, irq0}, {2'b00, e != 3'd0}, {t, " R11 irq"});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    check(code0, 3'd0, "R1 code after reset");
    check({2'b00, irq0}, 3'd0, "R1 irq after reset");
    rst = 0;
    tick(2);

    // R5 flow event, cleared by ISR read; R10 read returns old code
    flow_evt = 1; expect_code(3'd4, "R5 flow");
    tick(1);
    isr_rd = 1; check(code0, 3'd4, "R10 read value before clear");
    expect_code(3'd0, "R5 R10 flow cleared by isr read");

    // R5 modem delta ignores ISR read
    modem_delta = 1; expect_code(3'd4, "R5 modem");
    isr_rd = 1;      expect_code(3'd4, "R5 modem survives isr read");
    modem_rd = 1;    expect_code(3'd0, "R5 modem cleared");

    // R4 holding register empty
    thr_empty = 1;   expect_code(3'd3, "R4 thr rise");
    isr_rd = 1;      expect_code(3'd0, "R4 cleared by isr read");
    tick(2);         expect_code(3'd0, "R4 steady high no event");
    thr_empty = 0;   tick(2);

    // R4 auto485: shift register selects
    auto485 = 1; tick(2);
    thr_empty = 1;   expect_code(3'd0, "R4 thr ignored in auto485");
    tsr_empty = 1;   expect_code(3'd3, "R4 tsr rise");
    isr_rd = 1;      expect_code(3'd0, "R4 tsr cleared");
    thr_empty = 0; tsr_empty = 0; tick(1); auto485 = 0; tick(2);

    // R6 priority walk, R3 time-out, R8 timer
    rx_tmo = 1; flow_evt = 1; tmr_to = 1;
    expect_code(3'd2, "R6 R3 timeout highest");
    rx_rd = 1;       expect_code(3'd4, "R3 R6 flow next");
    isr_rd = 1;      expect_code(3'd7, "R6 R8 timer last");
    tick(1);
    check(code1, 3'd0, "R8 no timer on other channel");
    tmr_rd = 1;      expect_code(3'd0, "R8 timer cleared");

    // R2 each line error bit, and level source
    for (int b = 0; b < 4; b++) begin
      line_err = 4'h1 << b; expect_code(3'd1, "R2 line error bit");
      line_rd = 1;          expect_code(3'd0, "R2 line cleared");
    end
    rx_at_trig = 1;  expect_code(3'd1, "R2 rx level");
    modem_delta = 1; expect_code(3'd1, "R6 rx above modem");
    rx_at_trig = 0;  expect_code(3'd4, "R2 R6 drained shows modem");
    modem_rd = 1;    expect_code(3'd0, "R5 modem cleared");

    // R9 enable masks but latch records
    ien = 7'h5F;
    flow_evt = 1;    expect_code(3'd0, "R9 disabled flow hidden");
    ien = 7'h7F;
    tick(1);
    check(code0, 3'd4, "R9 enabled reveals latched flow");
    isr_rd = 1;      expect_code(3'd0, "R9 flow cleared");

    // R12 collisions: set and clear same cycle
    flow_evt = 1;    expect_code(3'd4, "R12 setup");
    flow_evt = 1; isr_rd = 1;       expect_code(3'd4, "R12 flow set wins");
    isr_rd = 1;                      expect_code(3'd0, "R12 flow then cleared");
    modem_delta = 1;                 expect_code(3'd4, "R12 modem setup");
    modem_delta = 1; modem_rd = 1;   expect_code(3'd4, "R12 modem set wins");
    modem_rd = 1;                    expect_code(3'd0, "R12 modem then cleared");

    // R7 reserved codes never seen on either channel
    check({2'b00, code0 == 3'd5 || code0 == 3'd6}, 3'd0, "R7 reserved u0");
    check({2'b00, code1 == 3'd5 || code1 == 3'd6}, 3'd0, "R7 reserved u1");

    wait (exp_q.size() == 0);
    tick(2);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule